// File: doc/BRIEF.md
# Fractional UART Bit-Clock Generator

This block derives serial bit timing from one source clock. An integer divisor sets the nominal length of a bit in source-clock cycles. An 8-bit stretch mask then adds one extra cycle to chosen bits of a character, which gives an effective divisor with a fraction. A start strobe begins a character. The block marks each bit boundary with a one-cycle pulse. Around the middle of every bit it takes three samples of the serial input, half a source cycle apart, using both clock edges. It reports the majority of these samples with a one-cycle strobe.

A receiver pulses `start` when it sees a falling start edge, and a transmitter pulses it when it launches a character. Both then follow `bit_tick` for bit boundaries. A receiver also takes `rx_bit` each time `mid_strobe` fires. Divisors below 3 are raised to 3, so the bit rate is at most one third of the source clock. Framing, parity and buffering belong to the surrounding logic.

Top module: `frac_bitclk_gen`

## Requirements
- R1: While `rst_n` is low or `enable` is low, `bit_tick` and `mid_strobe` stay 0 and `rx_bit` is 1. A `start` pulse received while disabled is ignored, so no tick appears after `enable` rises until a fresh `start` arrives.
- R2: The length of bit k of a character is Neff + m cycles. Here m = `stretch_mask[7 - (k mod 8)]`, so the mask MSB belongs to the start bit (bit 0) and the LSB belongs to bit 7.
- R3: The mask position wraps after 8 bits, so bit 8 uses the mask MSB again and bit 9 uses bit 6.
- R4: A `start` pulse, even one in the middle of a bit, restarts timing at bit 0. The first `bit_tick` then comes Neff + mask[7] cycles after the clock edge that samples `start`.
- R5: Neff equals `divisor` when `divisor` ≥ 3 and equals 3 otherwise. No two `bit_tick` pulses are fewer than 3 cycles apart.
- R6: `bit_tick` is a single-cycle pulse. It becomes visible in the cycle that follows the last cycle of a bit.
- R7: Let H = floor(Neff/2) + m. The three samples are taken H − ½, H and H + ½ source cycles after the bit begins. `rx_bit` takes their majority.
- R8: `mid_strobe` is a one-cycle pulse. It is visible H + 1 cycles after the bit begins, and never in the same cycle as `bit_tick`. While `enable` stays high, `rx_bit` changes only together with `mid_strobe`.
- R9: A glitch that corrupts only one of the three samples does not change the voted bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock; the serial input is also captured on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the generator; low holds all state cleared |
| start | input | 1 | One-cycle strobe that begins a character at bit 0 |
| divisor | input | DIV_W | Integer cycles per bit; values below 3 act as 3 |
| stretch_mask | input | 8 | Per-bit one-cycle stretch; MSB is the start bit |
| rx_in | input | 1 | Serial input to be sampled |
| bit_tick | output | 1 | One-cycle pulse at each bit boundary |
| mid_strobe | output | 1 | One-cycle pulse when a new voted bit is ready |
| rx_bit | output | 1 | Majority-voted value of the latest bit |

## Verification
On every cycle the assertions check several timing rules. Ticks and strobes last one cycle and never coincide. Ticks are at least three cycles apart. The voted bit holds between strobes. The block stays quiet while disabled. A restart returns the block to bit 0. The assertions cannot show that each bit has the exact length Neff + m for the right mask bit, that the mask wraps correctly over ten bits, or that the strobe sits at the correct offset. The bench scenarios measure these for several divisors and masks, including a clamped divisor. Placing glitches on chosen half-cycle sample points is likewise a bench-only check. It shows that one bad sample is outvoted and that two bad samples are not.

// File: rtl/frac_bitclk_pkg.sv
// Package: shared constants and helpers for the fractional bit-clock generator.
// Assumes the stretch mask is 8 bits with the MSB belonging to the start bit.
package frac_bitclk_pkg;

    localparam int MASK_LEN = 8;
    localparam int IDX_W    = $clog2(MASK_LEN);
    localparam int MIN_DIV  = 3;

    // Two-of-three majority of the mid-bit samples.
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/fbg_div_calc.sv
// Module: fbg_div_calc
// Turns the programmed divisor and stretch mask into the length of the current
// bit and its first-half length (the mid-bit point). Purely combinational.
// Assumes idx stays below MASK_LEN; divisors below MIN_DIV are raised to it.
module fbg_div_calc
    import frac_bitclk_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int CNT_W = DIV_W + 1
) (
    input  logic [DIV_W-1:0]    divisor,
    input  logic [MASK_LEN-1:0] stretch_mask,
    input  logic [IDX_W-1:0]    idx,
    output logic [CNT_W-1:0]    bit_len,
    output logic [CNT_W-1:0]    half_len
);

    logic [DIV_W-1:0] n_eff;
    logic             mod_bit;

    // Clamp the divisor to the lowest legal value.
    always_comb begin
        if (divisor < DIV_W'(MIN_DIV)) begin
            n_eff = DIV_W'(MIN_DIV);
        end else begin
            n_eff = divisor;
        end
    end

    // Pick the stretch bit for this bit position, MSB first.
    always_comb begin
        mod_bit = stretch_mask[(MASK_LEN - 1) - int'(idx)];
    end

    // Stretch adds one cycle to the whole bit and to its first half.
    always_comb begin
        bit_len  = CNT_W'(n_eff) + CNT_W'(mod_bit);
        half_len = CNT_W'(n_eff >> 1) + CNT_W'(mod_bit);
    end

endmodule

// File: rtl/fbg_bit_timer.sv
// Module: fbg_bit_timer
// Counts source cycles within a bit, advances the stretch-mask position at each
// bit boundary and emits a one-cycle tick after the last cycle of a bit.
// Assumes bit_len >= 3 (guaranteed by the divisor clamp upstream).
module fbg_bit_timer
    import frac_bitclk_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic [CNT_W-1:0] bit_len,
    output logic [CNT_W-1:0] cnt,
    output logic [IDX_W-1:0] idx,
    output logic             active,
    output logic             bit_tick
);

    logic last_cycle;
    logic idx_last;

    // Detect the final cycle of the bit and the final mask position.
    always_comb begin
        last_cycle = (cnt == bit_len - CNT_W'(1));
        idx_last   = (idx == IDX_W'(MASK_LEN - 1));
    end

    // Cycle counter, mask position and boundary tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt      <= '0;
            idx      <= '0;
            active   <= 1'b0;
            bit_tick <= 1'b0;
        end else if (start) begin
            cnt      <= '0;
            idx      <= '0;
            active   <= 1'b1;
            bit_tick <= 1'b0;
        end else if (active && last_cycle) begin
            cnt      <= '0;
            idx      <= idx_last ? '0 : idx + IDX_W'(1);
            bit_tick <= 1'b1;
        end else begin
            cnt      <= active ? cnt + CNT_W'(1) : cnt;
            bit_tick <= 1'b0;
        end
    end

    AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick); // R6

    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && idx == '0) |-> $past(idx) == IDX_W'(MASK_LEN - 1)); // R3

    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (start && enable) |=> (cnt == '0 && idx == '0 && active && !bit_tick)); // R4

endmodule

// File: rtl/fbg_vote_sampler.sv
// Module: fbg_vote_sampler
// Captures the serial input on both clock edges around mid-bit and registers
// the two-of-three majority together with a one-cycle ready strobe.
// Assumes cap_early and cap_late arrive on consecutive rising edges.
module fbg_vote_sampler
    import frac_bitclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic rx_in,
    input  logic cap_early,
    input  logic cap_late,
    output logic rx_bit,
    output logic mid_strobe
);

    logic fall_q;
    logic early_q;
    logic mid_q;

    // Half-cycle sample point: capture the input on every falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            fall_q <= 1'b1;
        end else begin
            fall_q <= rx_in;
        end
    end

    // Hold the first two samples, then vote with the third.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            early_q    <= 1'b1;
            mid_q      <= 1'b1;
            rx_bit     <= 1'b1;
            mid_strobe <= 1'b0;
        end else begin
            mid_strobe <= cap_late;
            if (cap_early) begin
                early_q <= fall_q;
                mid_q   <= rx_in;
            end
            if (cap_late) begin
                rx_bit <= vote3(early_q, mid_q, fall_q);
            end
        end
    end

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mid_strobe |=> !mid_strobe); // R8

    AST_RXBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && !mid_strobe) |-> $stable(rx_bit)); // R8

endmodule

// File: rtl/frac_bitclk_gen.sv
// Module: frac_bitclk_gen (top)
// Fractional bit-clock generator: integer divisor plus per-bit one-cycle
// stretch, boundary tick, and a majority-voted mid-bit sample.
// Assumes divisor and stretch_mask are held steady during a character.
module frac_bitclk_gen
    import frac_bitclk_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                start,
    input  logic [DIV_W-1:0]    divisor,
    input  logic [MASK_LEN-1:0] stretch_mask,
    input  logic                rx_in,
    output logic                bit_tick,
    output logic                mid_strobe,
    output logic                rx_bit
);

    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] bit_len;
    logic [CNT_W-1:0] half_len;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic             active;
    logic             cap_early;
    logic             cap_late;

    fbg_div_calc #(
        .DIV_W (DIV_W),
        .CNT_W (CNT_W)
    ) u_calc (
        .divisor      (divisor),
        .stretch_mask (stretch_mask),
        .idx          (idx),
        .bit_len      (bit_len),
        .half_len     (half_len)
    );

    fbg_bit_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .start    (start),
        .bit_len  (bit_len),
        .cnt      (cnt),
        .idx      (idx),
        .active   (active),
        .bit_tick (bit_tick)
    );

    // Sample windows: rising edge H (with falling edge H-1/2) and falling edge H+1/2.
    always_comb begin
        cap_early = active && !start && (cnt == half_len - CNT_W'(1));
        cap_late  = active && !start && (cnt == half_len);
    end

    fbg_vote_sampler u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .rx_in      (rx_in),
        .cap_early  (cap_early),
        .cap_late   (cap_late),
        .rx_bit     (rx_bit),
        .mid_strobe (mid_strobe)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!bit_tick && !mid_strobe && rx_bit)); // R1

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> (!$past(bit_tick) && !$past(bit_tick, 2))); // R5

    AST_STROBE_NOT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !(mid_strobe && bit_tick)); // R8

endmodule

// File: tb/tb_frac_bitclk_gen.sv
`timescale 1ns/1ps
module tb_frac_bitclk_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic        start;
    logic [15:0] divisor;
    logic [7:0]  stretch_mask;
    logic        rx_in;
    logic        bit_tick;
    logic        mid_strobe;
    logic        rx_bit;

    int n_tests = 0;
    int n_fail  = 0;

    // Vector table: {divisor, stretch mask}
    localparam int NVEC = 6;
    localparam logic [23:0] VEC [NVEC] = '{
        {16'd4, 8'h00}, {16'd5, 8'h01}, {16'd6, 8'h35},
        {16'd7, 8'hFF}, {16'd3, 8'h36}, {16'd1, 8'h37}
    };
    localparam int NBITS = 10;

    frac_bitclk_gen #(.DIV_W(16)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .start        (start),
        .divisor      (divisor),
        .stretch_mask (stretch_mask),
        .rx_in        (rx_in),
        .bit_tick     (bit_tick),
        .mid_strobe   (mid_strobe),
        .rx_bit       (rx_bit)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        enable = 1'b0;
        start  = 1'b0;
        rx_in  = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // Pulse start; returns 1 ns after the edge that samples it.
    task automatic pulse_start();
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
    endtask

    function automatic int neff_of(input int d);
        return (d < 3) ? 3 : d;
    endfunction

    // Place chosen values on the three sample points of bit 0 and check the vote.
    task automatic vote_case(input bit a, input bit b, input bit c, input bit exp, input string req);
        do_reset();
        divisor = 16'd8; stretch_mask = 8'h00; enable = 1'b1;
        @(posedge clk); #1;
        pulse_start();
        repeat (3) @(posedge clk);   // edge H-1 with H = 4
        #1 rx_in = a;                // covers falling edge H-1/2
        #3 rx_in = b;                // covers rising edge H
        #2 rx_in = c;                // covers falling edge H+1/2
        chk(mid_strobe == 1'b0, "R8 strobe early", int'(mid_strobe), 0);
        #5;                          // 1 ns after edge H+1
        chk(mid_strobe == 1'b1, "R8 strobe at H+1", int'(mid_strobe), 1);
        chk(rx_bit == exp, req, int'(rx_bit), int'(exp));
        rx_in = ~exp;
        @(posedge clk); #1;
        chk(rx_bit == exp && !mid_strobe, "R8 hold", int'(rx_bit), int'(exp));
    endtask

    initial begin : watchdog
        #1000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        divisor = 16'd4; stretch_mask = 8'h00;
        rst_n = 1'b0; enable = 1'b0; start = 1'b0; rx_in = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk(!bit_tick && !mid_strobe && rx_bit, "R1 reset state",
            {29'd0, bit_tick, mid_strobe, rx_bit}, 1);

        // Table walk: measure each bit length and the first strobe offset.
        for (int v = 0; v < NVEC; v++) begin
            int d;
            int ne;
            int cyc;
            int tot;
            int bitn;
            int mid_at;
            int guard;
            logic [7:0] pat;
            d   = int'(VEC[v][23:8]);
            pat = VEC[v][7:0];
            ne  = neff_of(d);
            do_reset();
            divisor = VEC[v][23:8]; stretch_mask = pat; enable = 1'b1;
            @(posedge clk); #1;
            pulse_start();
            cyc = 0; tot = 0; bitn = 0; mid_at = -1; guard = 0;
            while (bitn < NBITS && guard < 400) begin
                @(posedge clk); #1;
                cyc++; tot++; guard++;
                if (mid_strobe && mid_at < 0) mid_at = tot;
                if (bit_tick) begin
                    int m;
                    m = int'(pat[7 - (bitn % 8)]);
                    if (bitn >= 8)
                        chk(cyc == ne + m, "R3 wrapped bit length", cyc, ne + m);
                    else if (d < 3)
                        chk(cyc == ne + m, "R5 clamped bit length", cyc, ne + m);
                    else
                        chk(cyc == ne + m, "R2 bit length", cyc, ne + m);
                    bitn++;
                    cyc = 0;
                end
            end
            chk(bitn == NBITS, "R6 tick count", bitn, NBITS);
            chk(mid_at == ne / 2 + int'(pat[7]) + 1, "R8 strobe offset",
                mid_at, ne / 2 + int'(pat[7]) + 1);
        end

        // Disabled: start ignored, nothing emitted.
        begin
            int seen;
            do_reset();
            divisor = 16'd4; stretch_mask = 8'h00;
            pulse_start();
            seen = 0;
            for (int i = 0; i < 20; i++) begin
                rx_in = i[0];
                @(posedge clk); #1;
                if (bit_tick || mid_strobe || !rx_bit) seen++;
            end
            chk(seen == 0, "R1 quiet while disabled", seen, 0);
            enable = 1'b1; rx_in = 1'b1;
            seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(posedge clk); #1;
                if (bit_tick) seen++;
            end
            chk(seen == 0, "R1 start while disabled ignored", seen, 0);
        end

        // Restart in the middle of a bit returns to bit 0.
        begin
            int cyc;
            int ticks;
            do_reset();
            divisor = 16'd4; stretch_mask = 8'h80; enable = 1'b1;
            @(posedge clk); #1;
            pulse_start();
            ticks = 0;
            while (ticks < 2) begin
                @(posedge clk); #1;
                if (bit_tick) ticks++;
            end
            @(posedge clk); #1;
            pulse_start();
            cyc = 0;
            while (!bit_tick && cyc < 50) begin
                @(posedge clk); #1;
                cyc++;
            end
            chk(cyc == 5, "R4 restart first bit length", cyc, 5);
        end

        // Majority vote with chosen sample values.
        vote_case(1'b1, 1'b0, 1'b1, 1'b1, "R9 glitch on centre sample");
        vote_case(1'b0, 1'b1, 1'b1, 1'b1, "R9 glitch on early sample");
        vote_case(1'b0, 1'b0, 1'b1, 1'b0, "R7 two low samples win");
        vote_case(1'b1, 1'b1, 1'b0, 1'b1, "R9 glitch on late sample");
        vote_case(1'b0, 1'b1, 1'b0, 1'b0, "R9 high glitch rejected");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule